// File: doc/BRIEF.md
# UART Bit-Timing Generator

This block turns one baud clock into the timing strobes that a UART serializer and deserializer need. A programmable 16-bit divisor first slows the clock into prescaled ticks. A mode setting then decides how many of those ticks make up one bit: sixteen, four, or a count taken from a register. Within each bit the block raises a bit-boundary strobe on the last tick and a sample strobe on a chosen tick. In the two fixed modes the sample tick is the middle one. In the programmable mode the sample tick comes from a register.

Software programs the block through a small byte-wide register port. The two divisor bytes can be reached only while the latch-access bit (bit 7) of the line-control register is set. A receive-restart input, pulsed when a start edge is seen, throws away the bit in progress and starts timing afresh. New timing settings never disturb a bit that is already running: they are copied into the active set only at a bit boundary or on a restart.

Top module: `bitclk_gen`

## Requirements
- R1: After reset the divisor reads 1, and the line-control (address 3), mode (address 4), sample-count (address 5) and sample-point (address 6) registers read 0. Both strobes are low in the first cycle after reset.
- R2: With divisor d, one prescaled tick occurs every d clock cycles. A divisor of 0 acts as 1. Both strobes fire only in a cycle that carries a tick.
- R3: Mode value 0 (and the reserved value 1) gives 16 ticks per bit, with the sample strobe on tick index 8. The sample-point register is ignored in this mode.
- R4: Mode value 2 gives 4 ticks per bit, with the sample strobe on tick index 2.
- R5: Mode value 3 gives (sample count + 1) ticks per bit, with the sample strobe on the tick index held in the sample-point register.
- R6: The divisor low byte is at address 0 and the high byte at address 1. These bytes can be written and read only while line-control bit 7 is 1. Otherwise a write leaves the divisor unchanged and a read returns 0.
- R7: The line-control register reads back the full written byte. Clearing bit 7 keeps the character-length field in bits [1:0] (2'b11 = 8 bits).
- R8: Counting from the edge that samples rx_restart high as cycle boundary 0, the sample strobe fires (sp+1)*d-1 cycles later and the bit strobe fires N*d-1 cycles later. The bit strobe then repeats every N*d cycles. Here N is the number of ticks per bit and sp is the sample tick index.
- R9: Writes to the divisor, mode, sample count or sample point take effect only at the next bit boundary or restart. The bit in progress keeps its old timing.
- R10: In mode 3, a sample point greater than the sample count produces no sample strobe.
- R11: Neither strobe fires in a cycle in which rx_restart is high, even when that cycle would have ended a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baud clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| rx_restart | input | 1 | Start-edge restart of the bit timer |
| tick_o | output | 1 | Prescaled tick |
| bit_stb | output | 1 | Last tick of a bit |
| smp_stb | output | 1 | Receive sample tick |

## Verification
The case that needs the most care is a restart that arrives in the same cycle in which the bit timer would have closed a bit. Without care, this would mean two boundary actions at once. The bench sets up four-tick mode, counts to the exact cycle of a natural bit strobe and raises rx_restart there. It then expects both strobes to be low in that cycle, and the next boundary to come exactly four ticks after the restart. A second coincidence, a mode write landing one cycle into a fresh bit, is judged by requiring the old bit to finish with its old length before the new length appears.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

  typedef enum logic [1:0] {
    MODE_X16  = 2'd0,
    MODE_RSVD = 2'd1,
    MODE_X4   = 2'd2,
    MODE_PROG = 2'd3
  } tmode_e;

  // register addresses; divisor bytes occupy consecutive addresses from A_DIV0
  localparam int A_DIV0 = 0;
  localparam int A_LCR  = 3;
  localparam int A_MODE = 4;
  localparam int A_SCNT = 5;
  localparam int A_SPT  = 6;

endpackage

// File: rtl/bitclk_regs.sv
module bitclk_regs
  import bitclk_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_o,
  output tmode_e            mode_o,
  output logic [CNT_W-1:0]  scnt_o,
  output logic [CNT_W-1:0]  spt_o
);
  localparam int NB = DIV_W / DATA_W;

  logic [DATA_W-1:0] lcr_q, lcr_d;
  logic              lcr_en;
  logic              lab;
  tmode_e            mode_q, mode_d;
  logic              mode_en;
  logic [CNT_W-1:0]  scnt_q, scnt_d, spt_q, spt_d;
  logic              scnt_en, spt_en;

  assign lab = lcr_q[DATA_W-1];

  // divisor byte lanes, reachable only with the latch-access bit set
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [DATA_W-1:0] RST_V = (i == 0) ? DATA_W'(1) : '0;
    logic [DATA_W-1:0] b_q, b_d;
    logic              b_en;

    always_comb begin
      b_en = wr && lab && (addr == ADDR_W'(A_DIV0 + i));
      b_d  = b_en ? wdata : b_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= RST_V;
      else if (b_en) b_q <= b_d;
    end

    assign div_o[i*DATA_W +: DATA_W] = b_q;
  end

  always_comb begin
    lcr_en  = wr && (addr == ADDR_W'(A_LCR));
    mode_en = wr && (addr == ADDR_W'(A_MODE));
    scnt_en = wr && (addr == ADDR_W'(A_SCNT));
    spt_en  = wr && (addr == ADDR_W'(A_SPT));
    lcr_d   = lcr_en  ? wdata : lcr_q;
    mode_d  = mode_en ? tmode_e'(wdata[1:0]) : mode_q;
    scnt_d  = scnt_en ? wdata[CNT_W-1:0] : scnt_q;
    spt_d   = spt_en  ? wdata[CNT_W-1:0] : spt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      mode_q <= MODE_X16;
      scnt_q <= '0;
      spt_q  <= '0;
    end else begin
      if (lcr_en)  lcr_q  <= lcr_d;
      if (mode_en) mode_q <= mode_d;
      if (scnt_en) scnt_q <= scnt_d;
      if (spt_en)  spt_q  <= spt_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NB; k++) begin
      if (lab && (addr == ADDR_W'(A_DIV0 + k))) rdata = div_o[k*DATA_W +: DATA_W];
    end
    if (addr == ADDR_W'(A_LCR))  rdata = lcr_q;
    if (addr == ADDR_W'(A_MODE)) rdata = DATA_W'(mode_q);
    if (addr == ADDR_W'(A_SCNT)) rdata = DATA_W'(scnt_q);
    if (addr == ADDR_W'(A_SPT))  rdata = DATA_W'(spt_q);
  end

  assign mode_o = mode_q;
  assign scnt_o = scnt_q;
  assign spt_o  = spt_q;

endmodule

// File: rtl/bitclk_prescale.sv
module bitclk_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last;
  logic             hit;

  always_comb begin
    last   = (div_i == '0) ? '0 : div_i - 1'b1;
    hit    = (cnt_q >= last);
    tick_o = hit && !restart;
    if (restart || hit) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bitclk_shadow.sv
module bitclk_shadow
  import bitclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_i,
  input  tmode_e           mode_i,
  input  logic [CNT_W-1:0] scnt_i,
  input  logic [CNT_W-1:0] spt_i,
  output logic [DIV_W-1:0] div_o,
  output tmode_e           mode_o,
  output logic [CNT_W-1:0] scnt_o,
  output logic [CNT_W-1:0] spt_o
);
  logic [DIV_W-1:0] div_d;
  tmode_e           mode_d;
  logic [CNT_W-1:0] scnt_d, spt_d;

  always_comb begin
    div_d  = load ? div_i  : div_o;
    mode_d = load ? mode_i : mode_o;
    scnt_d = load ? scnt_i : scnt_o;
    spt_d  = load ? spt_i  : spt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o  <= DIV_W'(1);
      mode_o <= MODE_X16;
      scnt_o <= '0;
      spt_o  <= '0;
    end else if (load) begin
      div_o  <= div_d;
      mode_o <= mode_d;
      scnt_o <= scnt_d;
      spt_o  <= spt_d;
    end
  end

endmodule

// File: rtl/bitclk_bitctr.sv
module bitclk_bitctr
  import bitclk_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WIDE_N   = 16,
  parameter int NARROW_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  tmode_e           mode,
  input  logic [CNT_W-1:0] scnt,
  input  logic [CNT_W-1:0] spt,
  output logic             bit_stb,
  output logic             smp_stb,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_N - 1);
  localparam logic [CNT_W-1:0] WIDE_MID    = CNT_W'(WIDE_N / 2);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_N - 1);
  localparam logic [CNT_W-1:0] NARROW_MID  = CNT_W'(NARROW_N / 2);

  logic [CNT_W-1:0] idx_q, idx_d, last, samp;
  logic             idx_en;

  always_comb begin
    case (mode)
      MODE_X4:   begin last = NARROW_LAST; samp = NARROW_MID; end
      MODE_PROG: begin last = scnt;        samp = spt;        end
      default:   begin last = WIDE_LAST;   samp = WIDE_MID;   end
    endcase
  end

  always_comb begin
    idx_en = restart || tick;
    if (restart)            idx_d = '0;
    else if (idx_q == last) idx_d = '0;
    else                    idx_d = idx_q + 1'b1;
    bit_stb = tick && (idx_q == last);
    smp_stb = tick && (idx_q == samp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 8,
  parameter int WIDE_N   = 16,
  parameter int NARROW_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_restart,
  output logic              tick_o,
  output logic              bit_stb,
  output logic              smp_stb
);
  logic [DIV_W-1:0] pend_div, act_div;
  tmode_e           pend_mode, act_mode;
  logic [CNT_W-1:0] pend_scnt, pend_spt, act_scnt, act_spt;
  logic [CNT_W-1:0] tick_idx;
  logic             cfg_load;

  assign cfg_load = bit_stb || rx_restart;

  bitclk_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .div_o(pend_div), .mode_o(pend_mode), .scnt_o(pend_scnt),
    .spt_o(pend_spt)
  );

  bitclk_shadow #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .div_i(pend_div), .mode_i(pend_mode), .scnt_i(pend_scnt), .spt_i(pend_spt),
    .div_o(act_div), .mode_o(act_mode), .scnt_o(act_scnt), .spt_o(act_spt)
  );

  bitclk_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(rx_restart), .div_i(act_div), .tick_o(tick_o)
  );

  bitclk_bitctr #(.CNT_W(CNT_W), .WIDE_N(WIDE_N), .NARROW_N(NARROW_N)) u_bit (
    .clk(clk), .rst_n(rst_n), .restart(rx_restart), .tick(tick_o),
    .mode(act_mode), .scnt(act_scnt), .spt(act_spt),
    .bit_stb(bit_stb), .smp_stb(smp_stb), .idx_o(tick_idx)
  );

endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk
  import bitclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_restart,
  input logic             tick_o,
  input logic             bit_stb,
  input logic             smp_stb,
  input logic [CNT_W-1:0] tick_idx,
  input logic [DIV_W-1:0] pend_div,
  input tmode_e           pend_mode,
  input logic [CNT_W-1:0] pend_scnt,
  input logic [CNT_W-1:0] pend_spt,
  input logic [DIV_W-1:0] act_div,
  input tmode_e           act_mode,
  input logic [CNT_W-1:0] act_scnt,
  input logic [CNT_W-1:0] act_spt
);

  // R2
  smp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> tick_o);

  // R2
  bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> tick_o);

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart |=> (tick_idx == '0));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_stb || rx_restart) |=> ($stable(act_div) && $stable(act_mode) &&
                                  $stable(act_scnt) && $stable(act_spt)));

  // R9
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb || rx_restart) |=> (act_div == $past(pend_div) && act_mode == $past(pend_mode) &&
                                 act_scnt == $past(pend_scnt) && act_spt == $past(pend_spt)));

endmodule

bind bitclk_gen bitclk_gen_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_restart(rx_restart), .tick_o(tick_o),
  .bit_stb(bit_stb), .smp_stb(smp_stb), .tick_idx(tick_idx),
  .pend_div(pend_div), .pend_mode(pend_mode), .pend_scnt(pend_scnt), .pend_spt(pend_spt),
  .act_div(act_div), .act_mode(act_mode), .act_scnt(act_scnt), .act_spt(act_spt)
);

// File: tb/bitclk_gen_tb_top.sv
module bitclk_gen_tb_top;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       rx_restart;
  logic       tick_o, bit_stb, smp_stb;

  int n_chk  = 0;
  int n_fail = 0;

  bitclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_restart(rx_restart),
    .tick_o(tick_o), .bit_stb(bit_stb), .smp_stb(smp_stb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: divisor, mode, sample count, sample point, expected sample cycle, expected bit cycle
  // 16'hFFFF in the sample field means no sample strobe is expected
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {16'd1,   8'd0, 8'd0, 8'd0, 16'd8,     16'd15},
    {16'd3,   8'd0, 8'd0, 8'd0, 16'd26,    16'd47},
    {16'd2,   8'd1, 8'd0, 8'd0, 16'd17,    16'd31},
    {16'd5,   8'd2, 8'd0, 8'd0, 16'd14,    16'd19},
    {16'd0,   8'd2, 8'd0, 8'd0, 16'd2,     16'd3},
    {16'd2,   8'd3, 8'd9, 8'd4, 16'd9,     16'd19},
    {16'd1,   8'd3, 8'd5, 8'd5, 16'd5,     16'd5},
    {16'd1,   8'd3, 8'd3, 8'd7, 16'hFFFF,  16'd3},
    {16'd258, 8'd0, 8'd0, 8'd3, 16'd2321,  16'd4127},
    {16'd1,   8'd0, 8'd0, 8'd2, 16'd8,     16'd15}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic setup(input logic [15:0] dv, input logic [7:0] md,
                       input logic [7:0] sc, input logic [7:0] sp);
    wreg(3'd3, 8'h83);
    wreg(3'd0, dv[7:0]);
    wreg(3'd1, dv[15:8]);
    wreg(3'd3, 8'h03);
    wreg(3'd4, md);
    wreg(3'd5, sc);
    wreg(3'd6, sp);
  endtask

  // restart, then record the first two positions of each strobe
  task automatic measure(input int limit, input bit do_wr, input logic [2:0] a,
                         input logic [7:0] d, output int s1, output int s2,
                         output int b1, output int b2);
    s1 = -1; s2 = -1; b1 = -1; b2 = -1;
    @(negedge clk);
    rx_restart = 1'b1;
    @(negedge clk);
    rx_restart = 1'b0;
    if (do_wr) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    for (int j = 0; j < limit; j++) begin
      #1;
      if (smp_stb) begin if (s1 < 0) s1 = j; else if (s2 < 0) s2 = j; end
      if (bit_stb) begin if (b1 < 0) b1 = j; else if (b2 < 0) b2 = j; end
      @(negedge clk);
      reg_wr = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, s1, s2, b1, b2;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rx_restart = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "bit_stb after reset", int'(bit_stb), 0);
    chk("R1", "smp_stb after reset", int'(smp_stb), 0);
    rreg(3'd3, v); chk("R1", "lcr reset", v, 0);
    rreg(3'd4, v); chk("R1", "mode reset", v, 0);
    rreg(3'd5, v); chk("R1", "count reset", v, 0);
    rreg(3'd6, v); chk("R1", "point reset", v, 0);
    wreg(3'd3, 8'h80);
    rreg(3'd0, v); chk("R1", "divisor low reset", v, 1);
    rreg(3'd1, v); chk("R1", "divisor high reset", v, 0);

    // table of timing vectors
    for (int i = 0; i < NV; i++) begin
      logic [15:0] dv, es, eb;
      logic [7:0]  md, sc, sp;
      int de, n, lim, exs;
      string rq;
      {dv, md, sc, sp, es, eb} = VEC[i];
      setup(dv, md, sc, sp);
      de  = (dv == 0) ? 1 : int'(dv);
      n   = (int'(eb) + 1) / de;
      lim = 2 * n * de + 1;
      exs = (es == 16'hFFFF) ? -1 : int'(es);
      if (md == 8'd2)        rq = "R4";
      else if (md == 8'd3)   rq = (es == 16'hFFFF) ? "R10" : "R5";
      else                   rq = "R3";
      measure(lim, 1'b0, 3'd0, 8'd0, s1, s2, b1, b2);
      chk(rq, $sformatf("vec %0d first sample", i), s1, exs);
      chk("R8", $sformatf("vec %0d first bit", i), b1, int'(eb));
      chk("R2", $sformatf("vec %0d second bit", i), b2, 2 * (int'(eb) + 1) - 1);
    end

    // R6: divisor bytes closed while latch-access bit clear
    setup(16'd5, 8'd0, 8'd0, 8'd0);
    wreg(3'd0, 8'h77);
    rreg(3'd0, v); chk("R6", "divisor read while closed", v, 0);
    wreg(3'd3, 8'h83);
    rreg(3'd0, v); chk("R6", "divisor low kept", v, 5);
    rreg(3'd1, v); chk("R6", "divisor high kept", v, 0);
    rreg(3'd3, v); chk("R7", "lcr with latch bit", v, 8'h83);
    wreg(3'd3, 8'h03);
    rreg(3'd3, v); chk("R7", "lcr after latch cleared", v, 8'h03);
    measure(200, 1'b0, 3'd0, 8'd0, s1, s2, b1, b2);
    chk("R6", "timing uses kept divisor", b1, 79);

    // R9: mode write one cycle into a bit waits for the boundary
    setup(16'd1, 8'd0, 8'd0, 8'd0);
    measure(24, 1'b1, 3'd4, 8'd2, s1, s2, b1, b2);
    chk("R9", "old bit sample", s1, 8);
    chk("R9", "old bit length", b1, 15);
    chk("R9", "new mode sample", s2, 18);
    chk("R9", "new mode boundary", b2, 19);

    // R11: restart on the cycle of a natural boundary
    setup(16'd1, 8'd2, 8'd0, 8'd0);
    @(negedge clk); rx_restart = 1'b1;
    @(negedge clk); rx_restart = 1'b0;
    repeat (7) @(negedge clk);
    #1 chk("R4", "boundary before restart", int'(bit_stb), 1);
    rx_restart = 1'b1;
    #1;
    chk("R11", "bit strobe during restart", int'(bit_stb), 0);
    chk("R11", "sample strobe during restart", int'(smp_stb), 0);
    b1 = -1;
    @(negedge clk); rx_restart = 1'b0;
    for (int j = 0; j < 6; j++) begin
      #1 if (bit_stb && b1 < 0) b1 = j;
      @(negedge clk);
    end
    chk("R11", "boundary after coincident restart", b1, 3);

    finish_run();
  end

endmodule